// File: doc/BRIEF.md
# Read Completion Requirement Calculator

This block works out, for one memory read request, the largest number of completion header entries and completion data entries that the answer to that request could take up in the receive buffers. A completer may break a read answer at any Read Completion Boundary (RCB) that falls inside the requested range. The block therefore assumes the worst case: one completion for every RCB-sized address block that the request touches. Each piece then takes up whole beats of the receive data path.

A credit tracker upstream of the transmit queue hands each pending read to the block. It gives the low address bits, the byte length, the RCB setting and the data-path width. It then compares the two results with the free buffer entries before it lets the read go. Only the address bits below the larger RCB affect the result, so only those bits are taken in. Results are registered and handed over with a valid/ready handshake, so a new request can be taken on every cycle.

Top module: `rd_cpl_need_calc`

## Requirements
- R1: `rsp_hdr` equals the number of RCB-sized address blocks touched by the byte range starting at `req_ofs` with the effective length L, that is floor((ofs+L-1)/RCB) - floor(ofs/RCB) + 1.
- R2: `req_rcb` = 0 selects a 64-byte RCB and `req_rcb` = 1 selects a 128-byte RCB; with the 64-byte RCB only bits [5:0] of `req_ofs` matter.
- R3: `rsp_dat` equals the sum, over the pieces made by cutting the range at every RCB boundary, of ceil(piece bytes / beat bytes).
- R4: `req_path` 2'b00 gives 32-byte beats (256-bit path), 2'b01 gives 16-byte beats (128-bit path), and 2'b10 and 2'b11 both give 8-byte beats (64-bit path).
- R5: A `req_len` of 0 is treated as a length of 4 bytes (one dword).
- R6: A `req_len` above 4096 is treated as 4096.
- R7: A request taken at a clock edge (`req_valid` and `req_ready` high) has its result on `rsp_hdr`/`rsp_dat` with `rsp_valid` high right after that same edge.
- R8: While `rsp_valid` is high and `rsp_ready` is low, `rsp_hdr` and `rsp_dat` hold their values, `rsp_valid` stays high and `req_ready` is low.
- R9: `req_ready` is high whenever no result is held or the held result is being taken in the same cycle, so one request per cycle can flow through.
- R10: While `rst_n` is low, `rsp_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_ofs | input | 7 | Low start-address bits (below the 128-byte RCB) |
| req_len | input | 13 | Request length in bytes |
| req_rcb | input | 1 | RCB select: 0 = 64 bytes, 1 = 128 bytes |
| req_path | input | 2 | Receive data-path width select |
| rsp_valid | output | 1 | Result present |
| rsp_ready | input | 1 | Result taken this cycle |
| rsp_hdr | output | 7 | Worst-case completion header entries |
| rsp_dat | output | 10 | Worst-case completion data entries |

## Verification
Each result is due one edge after its request is taken: `rsp_valid`, `rsp_hdr` and `rsp_dat` change at the edge that takes the request, and `req_ready` follows `rsp_ready` within the same cycle. The bench changes inputs just after each rising edge. A behavioural model updates at the rising edge from those stable inputs. The design's outputs are compared with the model at the next falling edge, so every result is looked at in the cycle it is due. Stalled results are also checked against the previous falling edge's values to confirm they hold.

// File: rtl/rcr_pkg.sv
package rcr_pkg;

   // receive data-path width selector
   typedef enum logic [1:0] {
      PATH_WIDE     = 2'b00,
      PATH_MID      = 2'b01,
      PATH_NARROW   = 2'b10,
      PATH_NARROW_B = 2'b11
   } path_sel_e;

   localparam int NUM_PATHS   = 3;
   localparam int DWORD_BYTES = 4;

endpackage

// File: rtl/rcr_span.sv
// Splits a byte range at RCB boundaries: block count, first and last piece sizes.
module rcr_span #(
   parameter int RCB_SMALL = 64,
   parameter int RCB_LARGE = 128,
   parameter int LEN_W     = 13,
   parameter int OFS_W     = 7,
   parameter int HDR_W     = 7
) (
   input  logic [OFS_W-1:0] ofs,
   input  logic [LEN_W-1:0] len,
   input  logic             rcb_large,
   output logic [HDR_W-1:0] hdr,
   output logic [HDR_W-1:0] mid,
   output logic [LEN_W-1:0] first_piece,
   output logic [LEN_W-1:0] last_piece,
   output logic             single
);
   localparam int SPAN_W = LEN_W + 1;
   localparam int LG_S   = $clog2(RCB_SMALL);
   localparam int LG_L   = $clog2(RCB_LARGE);

   logic [SPAN_W-1:0] off_w, len_w, span, blk, first_room, tail, hdr_w;

   always_comb begin
      off_w = rcb_large ? SPAN_W'(ofs) : SPAN_W'(ofs & OFS_W'(RCB_SMALL - 1));
      blk   = rcb_large ? SPAN_W'(RCB_LARGE) : SPAN_W'(RCB_SMALL);
      len_w = SPAN_W'(len);
      span  = off_w + len_w;
      // index of block holding the last byte, plus one; offset lies in block 0
      hdr_w = ((span - SPAN_W'(1)) >> (rcb_large ? LG_L : LG_S)) + SPAN_W'(1);
      first_room = blk - off_w;
      tail       = span & (blk - SPAN_W'(1));
   end

   assign hdr         = HDR_W'(hdr_w);
   assign single      = (hdr_w == SPAN_W'(1));
   assign mid         = single ? '0 : HDR_W'(hdr_w - SPAN_W'(2));
   assign first_piece = (len_w < first_room) ? len : LEN_W'(first_room);
   assign last_piece  = (tail == '0) ? LEN_W'(blk) : LEN_W'(tail);

endmodule

// File: rtl/rcr_beats.sv
// Data entries for one beat width: each piece rounds up to whole beats.
module rcr_beats #(
   parameter int BEAT_BYTES = 32,
   parameter int RCB_SMALL  = 64,
   parameter int RCB_LARGE  = 128,
   parameter int LEN_W      = 13,
   parameter int HDR_W      = 7,
   parameter int DAT_W      = 10
) (
   input  logic [LEN_W-1:0] len,
   input  logic [LEN_W-1:0] first_piece,
   input  logic [LEN_W-1:0] last_piece,
   input  logic [HDR_W-1:0] mid,
   input  logic             single,
   input  logic             rcb_large,
   output logic [DAT_W-1:0] beats
);
   localparam int LG_B = $clog2(BEAT_BYTES);
   localparam int SH_S = $clog2(RCB_SMALL) - LG_B;
   localparam int SH_L = $clog2(RCB_LARGE) - LG_B;

   if (BEAT_BYTES > RCB_SMALL || (1 << LG_B) != BEAT_BYTES) begin : g_bad_beat
      $error("rcr_beats: beat must be a power of two no larger than the small RCB");
   end

   function automatic logic [DAT_W-1:0] ceil_beats(input logic [LEN_W-1:0] n);
      logic [LEN_W:0] t;
      t = (LEN_W+1)'(n) + (LEN_W+1)'(BEAT_BYTES - 1);
      return DAT_W'(t >> LG_B);
   endfunction

   logic [DAT_W-1:0] mid_beats;

   always_comb begin
      mid_beats = DAT_W'(mid) << (rcb_large ? SH_L : SH_S);
      if (single) beats = ceil_beats(len);
      else        beats = ceil_beats(first_piece) + ceil_beats(last_piece) + mid_beats;
   end

endmodule

// File: rtl/rcr_out_stage.sv
// One-entry result register with valid/ready on both sides.
module rcr_out_stage #(
   parameter int HDR_W = 7,
   parameter int DAT_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   output logic             in_ready,
   input  logic [HDR_W-1:0] in_hdr,
   input  logic [DAT_W-1:0] in_dat,
   output logic             out_valid,
   input  logic             out_ready,
   output logic [HDR_W-1:0] out_hdr,
   output logic [DAT_W-1:0] out_dat
);
   assign in_ready = !out_valid || out_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_hdr   <= '0;
         out_dat   <= '0;
      end else if (in_ready) begin
         out_valid <= in_valid;
         if (in_valid) begin
            out_hdr <= in_hdr;
            out_dat <= in_dat;
         end
      end
   end

   AST_ACCEPT_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && in_ready |=> out_valid); // R7
   AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid && $stable(out_hdr) && $stable(out_dat)); // R8

endmodule

// File: rtl/rd_cpl_need_calc.sv
module rd_cpl_need_calc
   import rcr_pkg::*;
#(
   parameter int MAX_LEN     = 4096,
   parameter int RCB_SMALL   = 64,
   parameter int RCB_LARGE   = 128,
   parameter int WIDE_BITS   = 256,
   parameter int MID_BITS    = 128,
   parameter int NARROW_BITS = 64,
   localparam int LEN_W    = $clog2(MAX_LEN) + 1,
   localparam int OFS_W    = $clog2(RCB_LARGE),
   localparam int HDR_W    = $clog2(MAX_LEN / RCB_SMALL + 2),
   localparam int DAT_W    = $clog2(MAX_LEN * 8 / NARROW_BITS + 3)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   output logic             req_ready,
   input  logic [OFS_W-1:0] req_ofs,
   input  logic [LEN_W-1:0] req_len,
   input  logic             req_rcb,
   input  logic [1:0]       req_path,
   output logic             rsp_valid,
   input  logic             rsp_ready,
   output logic [HDR_W-1:0] rsp_hdr,
   output logic [DAT_W-1:0] rsp_dat
);
   localparam int PATH_BITS [NUM_PATHS] = '{WIDE_BITS, MID_BITS, NARROW_BITS};

   if (RCB_SMALL >= RCB_LARGE || (1 << $clog2(RCB_SMALL)) != RCB_SMALL
       || (1 << $clog2(RCB_LARGE)) != RCB_LARGE) begin : g_bad_rcb
      $error("rd_cpl_need_calc: RCB sizes must be rising powers of two");
   end
   if (MAX_LEN < RCB_LARGE || (1 << $clog2(MAX_LEN)) != MAX_LEN) begin : g_bad_len
      $error("rd_cpl_need_calc: MAX_LEN must be a power of two >= large RCB");
   end
   if (WIDE_BITS < MID_BITS || MID_BITS < NARROW_BITS) begin : g_bad_path
      $error("rd_cpl_need_calc: path widths must be ordered wide >= mid >= narrow");
   end

   // effective length: zero means one dword, oversize clamps to MAX_LEN
   logic [LEN_W-1:0] len_eff;
   assign len_eff = (req_len == '0)              ? LEN_W'(DWORD_BYTES) :
                    (req_len > LEN_W'(MAX_LEN))  ? LEN_W'(MAX_LEN)     : req_len;

   logic [HDR_W-1:0] hdr, mid;
   logic [LEN_W-1:0] first_piece, last_piece;
   logic             single;

   rcr_span #(
      .RCB_SMALL(RCB_SMALL), .RCB_LARGE(RCB_LARGE),
      .LEN_W(LEN_W), .OFS_W(OFS_W), .HDR_W(HDR_W)
   ) i_span (
      .ofs(req_ofs), .len(len_eff), .rcb_large(req_rcb),
      .hdr(hdr), .mid(mid), .first_piece(first_piece),
      .last_piece(last_piece), .single(single)
   );

   logic [DAT_W-1:0] beats [NUM_PATHS];

   for (genvar g = 0; g < NUM_PATHS; g++) begin : g_path
      rcr_beats #(
         .BEAT_BYTES(PATH_BITS[g] / 8),
         .RCB_SMALL(RCB_SMALL), .RCB_LARGE(RCB_LARGE),
         .LEN_W(LEN_W), .HDR_W(HDR_W), .DAT_W(DAT_W)
      ) i_beats (
         .len(len_eff), .first_piece(first_piece), .last_piece(last_piece),
         .mid(mid), .single(single), .rcb_large(req_rcb), .beats(beats[g])
      );
   end

   logic [DAT_W-1:0] dat_sel;
   always_comb begin
      case (path_sel_e'(req_path))
         PATH_WIDE: dat_sel = beats[0];
         PATH_MID:  dat_sel = beats[1];
         default:   dat_sel = beats[2];
      endcase
   end

   rcr_out_stage #(.HDR_W(HDR_W), .DAT_W(DAT_W)) i_out (
      .clk(clk), .rst_n(rst_n),
      .in_valid(req_valid), .in_ready(req_ready),
      .in_hdr(hdr), .in_dat(dat_sel),
      .out_valid(rsp_valid), .out_ready(rsp_ready),
      .out_hdr(rsp_hdr), .out_dat(rsp_dat)
   );

   AST_HDR_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> rsp_hdr != '0); // R1
   AST_DAT_COVERS_HDR: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> rsp_dat >= DAT_W'(rsp_hdr)); // R3
   AST_PATH_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |-> beats[2] >= beats[1] && beats[1] >= beats[0]); // R4
   AST_STALL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && !rsp_ready |-> !req_ready); // R8
   AST_RESET_IDLE: assert property (@(posedge clk)
      !rst_n |=> !rsp_valid); // R10

endmodule

// File: tb/test_rd_cpl_need_calc.sv
`timescale 1ns/1ps
module test_rd_cpl_need_calc;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       req_valid = 1'b0;
   logic       req_ready;
   logic [6:0] req_ofs = '0;
   logic [12:0] req_len = '0;
   logic       req_rcb = 1'b0;
   logic [1:0] req_path = '0;
   logic       rsp_valid;
   logic       rsp_ready = 1'b1;
   logic [6:0] rsp_hdr;
   logic [9:0] rsp_dat;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;   // 250 MHz

   rd_cpl_need_calc i_rd_cpl_need_calc (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready),
      .req_ofs(req_ofs), .req_len(req_len), .req_rcb(req_rcb), .req_path(req_path),
      .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
      .rsp_hdr(rsp_hdr), .rsp_dat(rsp_dat)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
      end
   endtask

   // behavioural reference: walk the range piece by piece
   function automatic void model(input int ofs, input int len, input bit rcb, input int path,
                                 output int hdr, output int dat);
      int l, rcb_b, beat, pos, stop, nb, pe;
      l     = (len == 0) ? 4 : (len > 4096 ? 4096 : len);
      rcb_b = rcb ? 128 : 64;
      beat  = (path == 0) ? 32 : (path == 1 ? 16 : 8);
      pos   = ofs;
      stop  = ofs + l;
      hdr = 0; dat = 0;
      while (pos < stop) begin
         nb = (pos / rcb_b + 1) * rcb_b;
         pe = (nb < stop) ? nb : stop;
         hdr++;
         dat += (pe - pos + beat - 1) / beat;
         pos = pe;
      end
   endfunction

   // cycle model of the handshake stage
   bit m_vld = 1'b0;
   int m_hdr = 0, m_dat = 0;
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) m_vld <= 1'b0;
      else if (!m_vld || rsp_ready) begin
         if (req_valid) begin
            int h, d;
            model(req_ofs, req_len, req_rcb, req_path, h, d);
            m_hdr <= h;
            m_dat <= d;
         end
         m_vld <= req_valid;
      end
   end

   // compare on every falling edge
   bit p_stall = 1'b0;
   int p_hdr = 0, p_dat = 0;
   always @(negedge clk) begin
      if (!rst_n) begin
         chk(rsp_valid == 1'b0, "R10 reset valid", rsp_valid, 0);
         p_stall = 1'b0;
      end else begin
         chk(rsp_valid == m_vld, "R7 rsp_valid", rsp_valid, m_vld);
         chk(req_ready == (!m_vld || rsp_ready), "R9 req_ready", req_ready, !m_vld || rsp_ready);
         if (m_vld && rsp_valid) begin
            chk(rsp_hdr == m_hdr, "R1 header entries", rsp_hdr, m_hdr);
            chk(rsp_dat == m_dat, "R3 data entries", rsp_dat, m_dat);
         end
         if (p_stall) begin
            chk(rsp_valid && rsp_hdr == p_hdr, "R8 held header", rsp_hdr, p_hdr);
            chk(rsp_dat == p_dat, "R8 held data", rsp_dat, p_dat);
         end
         p_stall = rsp_valid && !rsp_ready;
         p_hdr   = rsp_hdr;
         p_dat   = rsp_dat;
      end
   end

   task automatic one(input int ofs, input int len, input bit rcb, input int path,
                      input int exp_h, input int exp_d, input string tag);
      @(posedge clk); #1;
      rsp_ready = 1'b1;
      req_valid = 1'b1;
      req_ofs = 7'(ofs); req_len = 13'(len); req_rcb = rcb; req_path = 2'(path);
      @(posedge clk); #1;
      req_valid = 1'b0;
      @(negedge clk);
      chk(rsp_valid, {tag, " valid"}, rsp_valid, 1);
      chk(rsp_hdr == exp_h, {tag, " header"}, rsp_hdr, exp_h);
      chk(rsp_dat == exp_d, {tag, " data"}, rsp_dat, exp_d);
   endtask

   initial begin
      repeat (5) @(posedge clk);
      #1 rst_n = 1'b1;

      one(7'h00, 192, 0, 0, 3, 6,  "R1 192B rcb64 wide");
      one(7'h00, 192, 0, 1, 3, 12, "R4 192B rcb64 mid");
      one(7'h00, 192, 0, 2, 3, 24, "R4 192B rcb64 narrow");
      one(7'h00, 192, 1, 0, 2, 6,  "R2 192B rcb128 wide");
      one(7'h20, 256, 0, 0, 5, 8,  "R1 256B off20 wide");
      one(7'h20, 256, 0, 1, 5, 16, "R3 256B off20 mid");
      one(7'h20, 256, 0, 2, 5, 32, "R3 256B off20 narrow");
      one(7'h20, 256, 0, 3, 5, 32, "R4 path code 3");
      one(7'h30, 32,  0, 0, 2, 2,  "R2 split at 64");
      one(7'h30, 32,  1, 0, 1, 1,  "R2 no split at 128");
      one(7'h3E, 0,   0, 0, 2, 2,  "R5 zero length");
      one(7'h00, 5000, 1, 0, 32, 128, "R6 clamp length");
      one(7'h20, 4096, 0, 2, 65, 512, "R6 max length narrow");

      // back-pressure: result must stay while stalled
      @(posedge clk); #1;
      rsp_ready = 1'b0; req_valid = 1'b1;
      req_ofs = 7'h05; req_len = 13'd100; req_rcb = 1'b0; req_path = 2'd1;
      @(posedge clk); #1;
      req_ofs = 7'h40; req_len = 13'd300;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk(!req_ready, "R8 ready low while stalled", req_ready, 0);
      @(posedge clk); #1;
      rsp_ready = 1'b1; req_valid = 1'b0;

      // random traffic with random back-pressure
      for (int i = 0; i < 3000; i++) begin
         @(posedge clk); #1;
         req_valid = ($urandom % 4) != 0;
         req_ofs   = 7'($urandom);
         req_len   = ($urandom % 8 == 0) ? 13'($urandom) : 13'($urandom % 600);
         req_rcb   = 1'($urandom);
         req_path  = 2'($urandom);
         rsp_ready = ($urandom % 4) != 0;
      end
      @(posedge clk); #1;
      req_valid = 1'b0; rsp_ready = 1'b1;
      repeat (4) @(posedge clk);
      @(negedge clk);
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
         $finish;
      end
   end

endmodule